// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit bidirectional ports, called A and B. Data can pass from either port to the other without inversion. Each direction has its own holding register, and each register has its own capture clock that loads on a falling edge. A per-direction select decides what the destination port shows: the live value on the opposite port, or the value held in that direction's register.

A global active-low output enable and a direction input decide which port, if either, is driven. Each tri-state port is split into an input, an output and an output enable, so the block stays synthesizable. The surrounding pad logic joins these three signals back into a real bus.

A port's input always reflects the external bus. Either register can therefore load data that arrives from outside, or data that the block itself is driving onto that port. Both registers can load while neither port is driven. This allows A data to be parked in one register and B data in the other.

Top module: `xcvr_bus_regs`

## Requirements
- R1: With `oe_n`=0, `dir`=1 and `sel_ab`=0, `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in` bit for bit, with no inversion.
- R2: With `oe_n`=0, `dir`=0 and `sel_ba`=0, `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in` bit for bit.
- R3: The A-to-B register loads `a_in` on a falling edge of `clk_ab`. A rising edge of `clk_ab` leaves it unchanged.
- R4: The B-to-A register loads `b_in` on a falling edge of `clk_ba`. A rising edge of `clk_ba` leaves it unchanged.
- R5: A select of 1 makes the driven port show that direction's register instead of live data: `b_out` shows the A-to-B register, and `a_out` shows the B-to-A register.
- R6: With `oe_n`=1, both `a_oe` and `b_oe` are 0, and both registers still load on their clock edges whatever `dir`, `sel_ab` and `sel_ba` are.
- R7: `a_oe` and `b_oe` are never 1 at the same time.
- R8: A port whose output enable is 0 presents an output value of 0.
- R9: A falling edge of a register's clock while `rst_n`=0 clears that register to 0.
- R10: A register can load the value the block is itself driving onto its source port, when the bus loops that value back to the port input.
- R11: In live mode the driven port follows a change on the opposite input with no clock edge at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register (falling edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (falling edge) |
| rst_n | input | 1 | Active-low reset, sampled on each register's own capture edge |
| oe_n | input | 1 | Active-low global output enable |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 held A-to-B register |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 held B-to-A register |
| a_in | input | 8 | Value seen on the A bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_oe | output | 1 | Drive enable of the A bus |
| b_in | input | 8 | Value seen on the B bus |
| b_out | output | 8 | Value driven onto the B bus |
| b_oe | output | 1 | Drive enable of the B bus |

## Verification
The bench checks edge polarity. It raises a capture clock and changes the data before the clock falls. A register built on the wrong edge would show the earlier data.

It loads both registers while neither port is driven, and then reads each one back through its own path. A design that gated capture with the enable, or swapped the two registers, would return stale or crossed data.

A loopback case feeds the driven B value back into `b_in` and captures it. This catches a design that sources a register from its own output instead of from the bus.

Live mode is checked with no clock activity at all. Random mixes of all the controls then catch any port driven while disabled or showing a value other than 0.

// File: rtl/xcvr_pkg.sv
// Shared encodings for the registered bus transceiver.
package xcvr_pkg;
    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
// Holding register loaded on the falling edge of its own clock.
// Assumes: the reset is sampled on that same falling edge (synchronous, active low).
module xcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Load or clear on the high-to-low transition of clk.
    always_ff @(negedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_route_ctrl.sv
// Decodes the global enable and the direction into one drive enable per port.
// Assumes: at most one port may be driven; with oe_n high neither is driven.
module xcvr_route_ctrl
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic drive_a,
    output logic drive_b
);
    xfer_dir_e dir_e;

    // Select the single destination port when the block is enabled.
    always_comb begin
        dir_e   = xfer_dir_e'(dir);
        drive_b = !oe_n && (dir_e == DIR_A_TO_B);
        drive_a = !oe_n && (dir_e == DIR_B_TO_A);
    end
endmodule

// File: rtl/xcvr_port_drive.sv
// Output stage for one port: picks live or held data and zeroes it when idle.
// Assumes: live data comes straight from the opposite port input, with no register.
module xcvr_port_drive
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             drive,
    input  logic             sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] dout,
    output logic             oe
);
    logic [WIDTH-1:0] chosen;

    // Choose the data source, then force the value to zero when not driving.
    always_comb begin
        chosen = (src_sel_e'(sel) == SRC_HELD) ? held : live;
        oe     = drive;
        dout   = drive ? chosen : '0;
    end
endmodule

// File: rtl/xcvr_bus_regs.sv
// Top level of the registered bidirectional transceiver between ports A and B.
// Assumes: each tri-state pin is split into in/out/oe, and pads merge them outside.
module xcvr_bus_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam int LANES = 2;  // lane 0: A to B, lane 1: B to A

    logic [WIDTH-1:0] src_bus   [LANES];
    logic [WIDTH-1:0] held_bus  [LANES];
    logic [WIDTH-1:0] dst_bus   [LANES];
    logic             lane_clk  [LANES];
    logic             lane_sel  [LANES];
    logic             lane_drv  [LANES];
    logic             lane_oe   [LANES];
    logic             drive_a;
    logic             drive_b;

    // Map the ports onto the two symmetric lanes.
    always_comb begin
        src_bus[0]  = a_in;
        src_bus[1]  = b_in;
        lane_clk[0] = clk_ab;
        lane_clk[1] = clk_ba;
        lane_sel[0] = sel_ab;
        lane_sel[1] = sel_ba;
        lane_drv[0] = drive_b;
        lane_drv[1] = drive_a;
    end

    xcvr_route_ctrl u_route (
        .oe_n    (oe_n),
        .dir     (dir),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (lane_clk[g]),
            .rst_n (rst_n),
            .d     (src_bus[g]),
            .q     (held_bus[g])
        );

        xcvr_port_drive #(.WIDTH(WIDTH)) u_drive (
            .drive (lane_drv[g]),
            .sel   (lane_sel[g]),
            .live  (src_bus[g]),
            .held  (held_bus[g]),
            .dout  (dst_bus[g]),
            .oe    (lane_oe[g])
        );
    end

    // Return the lane results to their destination ports.
    always_comb begin
        b_out = dst_bus[0];
        b_oe  = lane_oe[0];
        a_out = dst_bus[1];
        a_oe  = lane_oe[1];
    end
endmodule

// File: rtl/xcvr_bus_regs_chk.sv
// Checker for xcvr_bus_regs. It keeps its own copy of each holding register
// and compares the port behaviour against it on each capture edge.
module xcvr_bus_regs_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);
    logic [WIDTH-1:0] shadow_ab;
    logic [WIDTH-1:0] shadow_ba;
    logic             ok_ab = 1'b0;
    logic             ok_ba = 1'b0;

    // Track the A-to-B register contents as seen from the ports.
    always_ff @(negedge clk_ab) begin
        shadow_ab <= rst_n ? a_in : '0;
        ok_ab     <= 1'b1;
    end

    // Track the B-to-A register contents as seen from the ports.
    always_ff @(negedge clk_ba) begin
        shadow_ba <= rst_n ? b_in : '0;
        ok_ba     <= 1'b1;
    end

    AST_SINGLE_DRIVER: assert property (@(negedge clk_ab) disable iff (!rst_n) !(a_oe && b_oe)); // R7
    AST_IDLE_NO_DRIVE: assert property (@(negedge clk_ba) disable iff (!rst_n) oe_n |-> (!a_oe && !b_oe)); // R6
    AST_A_IDLE_ZERO: assert property (@(negedge clk_ba) disable iff (!rst_n) !a_oe |-> (a_out == '0)); // R8
    AST_B_IDLE_ZERO: assert property (@(negedge clk_ab) disable iff (!rst_n) !b_oe |-> (b_out == '0)); // R8
    AST_B_HELD_DATA: assert property (@(negedge clk_ab) disable iff (!rst_n) (ok_ab && b_oe && sel_ab) |-> (b_out == shadow_ab)); // R5
    AST_A_HELD_DATA: assert property (@(negedge clk_ba) disable iff (!rst_n) (ok_ba && a_oe && sel_ba) |-> (a_out == shadow_ba)); // R5
    AST_B_LIVE_DATA: assert property (@(negedge clk_ab) disable iff (!rst_n) (b_oe && !sel_ab) |-> (b_out == a_in)); // R1
    AST_A_LIVE_DATA: assert property (@(negedge clk_ba) disable iff (!rst_n) (a_oe && !sel_ba) |-> (a_out == b_in)); // R2
endmodule

bind xcvr_bus_regs xcvr_bus_regs_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst_n  (rst_n),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/xcvr_bus_regs_test.sv
// Self-checking bench for xcvr_bus_regs: directed corner cases plus seeded random mixes.
module xcvr_bus_regs_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
    logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    int           checks = 0, fails = 0, cycles = 0;

    xcvr_bus_regs #(.WIDTH(W)) uut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [W-1:0] exp_b(logic [W-1:0] mab);
        return (!oe_n && dir) ? (sel_ab ? mab : a_in) : '0;
    endfunction

    function automatic logic [W-1:0] exp_a(logic [W-1:0] mba);
        return (!oe_n && !dir) ? (sel_ba ? mba : b_in) : '0;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " b_out"}, b_out, exp_b(m_ab));
        chk({tag, " a_out"}, a_out, exp_a(m_ba));
        chk({tag, " b_oe"}, {7'd0, b_oe}, {7'd0, !oe_n && dir});
        chk({tag, " a_oe"}, {7'd0, a_oe}, {7'd0, !oe_n && !dir});
    endtask

    task automatic pulse_ab();
        clk_ab = 1'b1; #2;
        clk_ab = 1'b0;
        m_ab = rst_n ? a_in : '0;
        #2;
    endtask

    task automatic pulse_ba();
        clk_ba = 1'b1; #2;
        clk_ba = 1'b0;
        m_ba = rst_n ? b_in : '0;
        #2;
    endtask

    initial begin
        void'($urandom(32'h1A2B_3C4D));
        // R9: reset clears both registers on their falling edges
        a_in = 8'hFF; b_in = 8'hFF;
        #3; pulse_ab(); pulse_ba();
        rst_n = 1'b1;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R9 reset clears AB register", b_out, 8'h00);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R9 reset clears BA register", a_out, 8'h00);

        // R1: live A to B, non-inverting
        dir = 1'b1; sel_ab = 1'b0; a_in = 8'hA5; #1;
        chk("R1 live A to B", b_out, 8'hA5);
        chk("R1 A not driven", {7'd0, a_oe}, 8'h00);
        // R11: change without any clock edge
        a_in = 8'h3C; #1;
        chk("R11 live follows without clock", b_out, 8'h3C);

        // R2: live B to A
        dir = 1'b0; sel_ba = 1'b0; b_in = 8'h5A; #1;
        chk("R2 live B to A", a_out, 8'h5A);
        chk("R2 B not driven", {7'd0, b_oe}, 8'h00);

        // R3: rising edge alone does not load the AB register
        dir = 1'b1; sel_ab = 1'b1; a_in = 8'h11;
        clk_ab = 1'b1; #2;
        chk("R3 rising edge has no effect", b_out, 8'h00);
        a_in = 8'h22; #1;
        clk_ab = 1'b0; m_ab = 8'h22; #1;
        chk("R3 falling edge loads", b_out, 8'h22);
        chk("R5 held data shown on B", b_out, m_ab);

        // R4: same for the BA register
        dir = 1'b0; sel_ba = 1'b1; b_in = 8'h44;
        clk_ba = 1'b1; #2;
        chk("R4 rising edge has no effect", a_out, 8'h00);
        b_in = 8'h66; #1;
        clk_ba = 1'b0; m_ba = 8'h66; #1;
        chk("R4 falling edge loads", a_out, 8'h66);

        // R6: load both registers while idle, then read them back
        oe_n = 1'b1; a_in = 8'hC3; b_in = 8'h81; #1;
        chk("R6 idle B not driven", {7'd0, b_oe}, 8'h00);
        chk("R6 idle A not driven", {7'd0, a_oe}, 8'h00);
        chk("R8 idle outputs zero", a_out | b_out, 8'h00);
        pulse_ab(); pulse_ba();
        a_in = 8'h00; b_in = 8'h00;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R6 AB loaded while idle", b_out, 8'hC3);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R6 BA loaded while idle", a_out, 8'h81);

        // R10: capture the block's own drive looped back on port B
        dir = 1'b1; sel_ab = 1'b0; a_in = 8'h9E; #1;
        b_in = b_out;
        pulse_ba();
        b_in = 8'h00; dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R10 looped-back drive captured", a_out, 8'h9E);

        // Random mixes covering R1 R2 R5 R7 R8
        for (int i = 0; i < 400; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            {oe_n, dir, sel_ab, sel_ba} = 4'($urandom);
            if ($urandom % 3 == 0) pulse_ab();
            if ($urandom % 3 == 0) pulse_ba();
            #1;
            chk_all("R1/R2/R5/R8 random");
            chk("R7 single driver", {7'd0, a_oe & b_oe}, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule